// File: doc/BRIEF.md
# Three-Group Interrupt Priority Encoder

This block gathers interrupt requests from three groups of sources: critical, main and peripheral. Each group has its own mask register, in which a set bit disables a source. Every clock the block builds one encoded status word with a separate field for each group. Each field holds the lowest-numbered enabled pending source of its group and a valid flag. Software reads that word and serves the critical field first, then the main field, then the peripheral field. A single level-sensitive request line to the processor is high whenever any of the three fields is valid.

A peripheral source can be promoted. A high-promoted source shows up as code 2 in the critical field. A medium-promoted source shows up as code 4 in the main field. The peripheral field then reports the promoted source, so a handler that finds one of these codes can read the actual source number from the peripheral field. The processor writes and reads the masks and the two promotion selects through a small word-addressed register port. The status word is read-only at the same port.

Top module: `irq_group_encoder`

## Requirements
- R1: After reset, the registers read as follows: main mask 0x00010fff, peripheral mask 0x7ffffc00, critical mask 0x0000000b, both promotion selects 0. The status word is 0 and irqOut is low. With these values no request can make a field valid.
- R2: Status word layout:
  - critical code in bits 9:8, with its valid flag in bit 10;
  - main code in bits 20:16, with its valid flag in bit 21;
  - peripheral code in bits 28:24, with its valid flag in bit 29.
  All other bits are zero, and the code of a field that is not valid is zero.
- R3: Critical codes map as follows: code 0 is critReq[0], code 1 is critReq[1], code 3 is critReq[2]. Critical mask bit n disables code n. The lowest valid code wins, with code 2 taking part as described in R6.
- R4: Main source n, for n = 0 or 5..16, is mainReq[n] and is disabled by main mask bit (16 − n). The lowest enabled pending code wins, with code 4 taking part as described in R7. mainReq[4:1] are ignored.
- R5: Peripheral source n, for n = 1..21, is periReq[n] and is disabled by peripheral mask bit (31 − n). periReq[0] is ignored and can never make the peripheral field valid.
- R6: Setting bit (31 − n) of the high-promotion select turns an enabled pending peripheral source n into critical code 2.
- R7: Setting bit (31 − n) of the medium-promotion select, with the high bit for that source clear, turns an enabled pending peripheral source n into main code 4.
- R8: The peripheral field reports the lowest high-promoted pending source if there is one. Otherwise it reports the lowest medium-promoted pending source. Otherwise it reports the lowest enabled pending source.
- R9: The status word is registered. It reflects the requests and register contents present before the previous clock edge. A mask written at one edge therefore changes the status one cycle later, and a source masked while pending leaves the word on that following cycle.
- R10: irqOut is high exactly when at least one of the three valid flags in the current status word is set.
- R11: Register addresses:
  - 0: main mask (writable bits 16 and 11:0)
  - 1: peripheral mask (writable bits 30:10)
  - 2: critical mask (writable bits 3, 1, 0)
  - 3: high-promotion select (writable bits 30:10)
  - 4: medium-promotion select (writable bits 30:10)
  - 5: status (read-only; writes are ignored)
  - 6 and 7: read as zero
  Bits outside the writable set read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| critReq | input | 3 | Critical group requests |
| mainReq | input | 17 | Main group requests, indexed by source code |
| periReq | input | 22 | Peripheral group requests, indexed by source code |
| regAddr | input | 3 | Register word address for read and write |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed register, combinational |
| irqOut | output | 1 | Level interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is a set of competing promoted and plain peripheral sources together with real critical and main requests. Only that combination shows whether code 2 and code 4 rank correctly against true sources, and whether the peripheral field picks the promoted source rather than a lower-numbered plain one. Directed cases first program the promotion selects through the register port and then raise mixed requests. A long random phase then rewrites masks and selects with sparse values while requests toggle, so that masking a source that is already pending comes up many times.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

  localparam int WORD_W = 32;
  localparam int CRIT_N = 3;
  localparam int MAIN_N = 17;
  localparam int PERI_N = 22;

  // register word addresses
  localparam int A_MAIN_MASK = 0;
  localparam int A_PERI_MASK = 1;
  localparam int A_CRIT_MASK = 2;
  localparam int A_HI_SEL    = 3;
  localparam int A_MID_SEL   = 4;
  localparam int A_STATUS    = 5;

  // implemented bits and reset values
  localparam logic [WORD_W-1:0] MAIN_WR_BITS = 32'h0001_0fff;
  localparam logic [WORD_W-1:0] PERI_WR_BITS = 32'h7fff_fc00;
  localparam logic [WORD_W-1:0] CRIT_WR_BITS = 32'h0000_000b;

  // status field positions (decoded by software)
  localparam int CRIT_LO = 8;
  localparam int CRIT_V  = 10;
  localparam int MAIN_LO = 16;
  localparam int MAIN_V  = 21;
  localparam int PERI_LO = 24;
  localparam int PERI_V  = 29;

  // promoted codes
  localparam logic [1:0] CRIT_PROMO_CODE = 2'd2;
  localparam int         MAIN_PROMO_CODE = 4;

  typedef struct packed {
    logic mainMaskWr;
    logic periMaskWr;
    logic critMaskWr;
    logic hiSelWr;
    logic midSelWr;
  } regStrobe_t;

  function automatic logic [4:0] lowestSet(input logic [31:0] v);
    logic [4:0] idx;
    idx = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = 5'(i);
    end
    return idx;
  endfunction

  function automatic logic [1:0] lowest4(input logic [3:0] v);
    logic [1:0] idx;
    idx = '0;
    for (int i = 3; i >= 0; i--) begin
      if (v[i]) idx = 2'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobe_t        strobes
);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      strobes.mainMaskWr = (wrAddr == ADDR_W'(A_MAIN_MASK));
      strobes.periMaskWr = (wrAddr == ADDR_W'(A_PERI_MASK));
      strobes.critMaskWr = (wrAddr == ADDR_W'(A_CRIT_MASK));
      strobes.hiSelWr    = (wrAddr == ADDR_W'(A_HI_SEL));
      strobes.midSelWr   = (wrAddr == ADDR_W'(A_MID_SEL));
    end
  end

  // R11: at most one register written per cycle
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  // R11: status address and upper addresses never produce a write
  p_status_ro_r11: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr >= ADDR_W'(A_STATUS)) |-> (strobes == '0));

endmodule

// File: rtl/irq_group_dp.sv
module irq_group_dp
  import irq_group_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CRIT_N-1:0] critReq,
  input  logic [MAIN_N-1:0] mainReq,
  input  logic [PERI_N-1:0] periReq,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);

  logic [WORD_W-1:0] mainMaskQ, periMaskQ, critMaskQ, hiSelQ, midSelQ;
  logic [WORD_W-1:0] statusQ, statusD;
  logic [31:0]       periActive, hiHit, midHit, mainEff, periPick;
  logic [3:0]        critEff;
  logic              pastOk;

  // register storage: only implemented bits are kept
  always_ff @(posedge clk) begin
    if (rst) begin
      mainMaskQ <= MAIN_WR_BITS;
      periMaskQ <= PERI_WR_BITS;
      critMaskQ <= CRIT_WR_BITS;
      hiSelQ    <= '0;
      midSelQ   <= '0;
      statusQ   <= '0;
      pastOk    <= 1'b0;
    end else begin
      if (strobes.mainMaskWr) mainMaskQ <= wrData & MAIN_WR_BITS;
      if (strobes.periMaskWr) periMaskQ <= wrData & PERI_WR_BITS;
      if (strobes.critMaskWr) critMaskQ <= wrData & CRIT_WR_BITS;
      if (strobes.hiSelWr)    hiSelQ    <= wrData & PERI_WR_BITS;
      if (strobes.midSelWr)   midSelQ   <= wrData & PERI_WR_BITS;
      statusQ <= statusD;
      pastOk  <= 1'b1;
    end
  end

  // per-source gating of the peripheral group
  for (genvar n = 0; n < 32; n++) begin : g_peri
    if (n >= 1 && n < PERI_N) begin : g_src
      assign periActive[n] = periReq[n] & ~periMaskQ[31-n];
      assign hiHit[n]      = periActive[n] & hiSelQ[31-n];
      assign midHit[n]     = periActive[n] & midSelQ[31-n] & ~hiSelQ[31-n];
    end else begin : g_none
      assign periActive[n] = 1'b0;
      assign hiHit[n]      = 1'b0;
      assign midHit[n]     = 1'b0;
    end
  end

  // per-source gating of the main group, code 4 carries medium promotion
  for (genvar n = 0; n < 32; n++) begin : g_main
    if (n == 0 || (n >= 5 && n < MAIN_N)) begin : g_src
      assign mainEff[n] = mainReq[n] & ~mainMaskQ[16-n];
    end else if (n == MAIN_PROMO_CODE) begin : g_promo
      assign mainEff[n] = |midHit;
    end else begin : g_none
      assign mainEff[n] = 1'b0;
    end
  end

  assign critEff = {critReq[2] & ~critMaskQ[3], |hiHit,
                    critReq[1] & ~critMaskQ[1], critReq[0] & ~critMaskQ[0]};

  assign periPick = (|hiHit) ? hiHit : ((|midHit) ? midHit : periActive);

  always_comb begin
    statusD = '0;
    statusD[CRIT_V]        = |critEff;
    statusD[CRIT_LO +: 2]  = lowest4(critEff);
    statusD[MAIN_V]        = |mainEff;
    statusD[MAIN_LO +: 5]  = lowestSet(mainEff);
    statusD[PERI_V]        = |periActive;
    statusD[PERI_LO +: 5]  = lowestSet(periPick);
  end

  assign irqOut = statusQ[CRIT_V] | statusQ[MAIN_V] | statusQ[PERI_V];

  always_comb begin
    case (rdAddr)
      ADDR_W'(A_MAIN_MASK): rdData = mainMaskQ;
      ADDR_W'(A_PERI_MASK): rdData = periMaskQ;
      ADDR_W'(A_CRIT_MASK): rdData = critMaskQ;
      ADDR_W'(A_HI_SEL):    rdData = hiSelQ;
      ADDR_W'(A_MID_SEL):   rdData = midSelQ;
      ADDR_W'(A_STATUS):    rdData = statusQ;
      default:              rdData = '0;
    endcase
  end

  // R1: status and request line clear right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (statusQ == '0 && !irqOut));

  // R3: critical code 3 only for an enabled third critical request
  p_crit_src_r3: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (statusQ[CRIT_V] && statusQ[CRIT_LO +: 2] == 2'd3) |->
      $past(critReq[2] && !critMaskQ[3] && !(|hiHit)));

  // R4: ignored main requests alone never validate the main field
  p_main_ignored_r4: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (mainReq[4:1] != 4'b0 && mainEff == 32'b0) |=> !statusQ[MAIN_V]);

  // R5: reported peripheral source was pending and enabled
  p_peri_src_r5: assert property (@(posedge clk) disable iff (rst || !pastOk)
    statusQ[PERI_V] |->
      (($past(periActive) & (32'd1 << statusQ[PERI_LO +: 5])) != 32'b0));

  // R5: the ignored peripheral request never validates the field
  p_peri_ignored_r5: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (periReq[0] && periActive == 32'b0) |=> !statusQ[PERI_V]);

  // R6: high promotion appears in the critical field
  p_promo_hi_r6: assert property (@(posedge clk) disable iff (rst || !pastOk)
    $past(|hiHit) |-> (statusQ[CRIT_V] && statusQ[CRIT_LO +: 2] <= CRIT_PROMO_CODE));

  // R7: medium promotion appears in the main field
  p_promo_mid_r7: assert property (@(posedge clk) disable iff (rst || !pastOk)
    $past(|midHit) |-> (statusQ[MAIN_V] && statusQ[MAIN_LO +: 5] <= 5'(MAIN_PROMO_CODE)));

  // R10: request line follows the pending state of the prior cycle
  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst || !pastOk)
    irqOut == $past((|critEff) || (|mainEff) || (|periActive)));

endmodule

// File: rtl/irq_group_encoder.sv
module irq_group_encoder
  import irq_group_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CRIT_N-1:0] critReq,
  input  logic [MAIN_N-1:0] mainReq,
  input  logic [PERI_N-1:0] periReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              irqOut
);

  regStrobe_t strobes;

  irq_group_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (regWrEn),
    .wrAddr  (regAddr),
    .strobes (strobes)
  );

  irq_group_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .critReq (critReq),
    .mainReq (mainReq),
    .periReq (periReq),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/test_irq_group_encoder.sv
module test_irq_group_encoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [21:0] periReq = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the registers (from R1 and R11)
  logic [31:0] mMask = 32'h0001_0fff;
  logic [31:0] pMask = 32'h7fff_fc00;
  logic [31:0] cMask = 32'h0000_000b;
  logic [31:0] hSel  = '0;
  logic [31:0] dSel  = '0;

  irq_group_encoder i_irq_group_encoder (
    .clk(clk), .rst(rst), .critReq(critReq), .mainReq(mainReq),
    .periReq(periReq), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] modelStatus();
    logic [31:0] s;
    int c, m, p, pHi, pMid;
    s = '0; c = -1; m = -1; p = -1; pHi = -1; pMid = -1;
    for (int n = 21; n >= 1; n--) begin
      if (periReq[n] && !pMask[31-n]) begin
        p = n;
        if (hSel[31-n]) pHi = n;
        else if (dSel[31-n]) pMid = n;
      end
    end
    if (critReq[0] && !cMask[0]) c = 0;
    else if (critReq[1] && !cMask[1]) c = 1;
    else if (pHi >= 0) c = 2;
    else if (critReq[2] && !cMask[3]) c = 3;
    if (mainReq[0] && !mMask[16]) m = 0;
    else if (pMid >= 0) m = 4;
    else begin
      for (int n = 16; n >= 5; n--) if (mainReq[n] && !mMask[16-n]) m = n;
    end
    if (pHi >= 0) p = pHi;
    else if (pMid >= 0) p = pMid;
    if (c >= 0) begin s[10] = 1'b1; s[9:8]   = 2'(c); end
    if (m >= 0) begin s[21] = 1'b1; s[20:16] = 5'(m); end
    if (p >= 0) begin s[29] = 1'b1; s[28:24] = 5'(p); end
    return s;
  endfunction

  task automatic applyWrite(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: mMask = d & 32'h0001_0fff;
      3'd1: pMask = d & 32'h7fff_fc00;
      3'd2: cMask = d & 32'h0000_000b;
      3'd3: hSel  = d & 32'h7fff_fc00;
      3'd4: dSel  = d & 32'h7fff_fc00;
      default: ;
    endcase
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; status checked at following negedge
  task automatic cycle(input string tag);
    logic [31:0] e;
    e = modelStatus();
    @(posedge clk);
    if (regWrEn) applyWrite(regAddr, regWrData);
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = 3'd5;
    #1;
    chk(regRdData, e, tag);
    chk({31'b0, irqOut}, {31'b0, e[10] | e[21] | e[29]}, "R10 irqOut");
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    cycle(tag);
  endtask

  task automatic readChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdData, exp, tag);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset contents
    readChk(3'd0, 32'h0001_0fff, "R1 main mask reset");
    readChk(3'd1, 32'h7fff_fc00, "R1 peri mask reset");
    readChk(3'd2, 32'h0000_000b, "R1 crit mask reset");
    readChk(3'd3, 32'h0, "R1 hi select reset");
    readChk(3'd4, 32'h0, "R1 mid select reset");
    readChk(3'd5, 32'h0, "R1 status reset");
    chk({31'b0, irqOut}, 32'h0, "R1 irqOut reset");

    // R1: all requests high while everything is masked
    critReq = '1; mainReq = '1; periReq = '1;
    cycle("R1 all masked");
    cycle("R1 all masked hold");

    // R11: implemented bits only
    critReq = '0; mainReq = '0; periReq = '0;
    for (int a = 0; a < 5; a++) wr(3'(a), 32'hffff_ffff, "R11 write ones");
    readChk(3'd0, 32'h0001_0fff, "R11 main bits");
    readChk(3'd1, 32'h7fff_fc00, "R11 peri bits");
    readChk(3'd2, 32'h0000_000b, "R11 crit bits");
    readChk(3'd3, 32'h7fff_fc00, "R11 hi bits");
    readChk(3'd4, 32'h7fff_fc00, "R11 mid bits");
    for (int a = 0; a < 5; a++) wr(3'(a), 32'h0, "R11 clear");
    wr(3'd5, 32'hffff_ffff, "R11 status write ignored");
    readChk(3'd5, 32'h0, "R11 status unchanged");
    wr(3'd6, 32'hffff_ffff, "R11 addr6 write");
    readChk(3'd6, 32'h0, "R11 addr6 zero");
    readChk(3'd7, 32'h0, "R11 addr7 zero");
    readChk(3'd0, 32'h0, "R11 main after ignored writes");

    // R4: ignored main codes
    mainReq = 17'b0_0000_0000_0001_1110;
    cycle("R4 ignored main codes");
    mainReq = 17'h1_0000 | 17'h0_0100;
    cycle("R4 lowest main wins code 8");
    // R5: ignored peripheral bit, lowest wins
    mainReq = '0; periReq = 22'h00_0001;
    cycle("R5 ignored peri bit0");
    periReq = 22'h20_1200;
    cycle("R5 lowest peri code 9");
    // R3: critical codes and masking
    periReq = '0; critReq = 3'b110;
    cycle("R3 crit code 1");
    wr(3'd2, 32'h2, "R3 mask code 1 write");
    cycle("R3 crit code 3 after mask");
    wr(3'd2, 32'h0, "R3 unmask");

    // R6/R8: high promotion of source 7 with plain source 3 pending
    critReq = '0;
    wr(3'd3, 32'h1 << (31 - 7), "R6 hi select write");
    periReq = (22'h1 << 7) | (22'h1 << 3);
    cycle("R6 R8 crit code 2, peri reports 7");
    critReq = 3'b010;
    cycle("R6 crit code 1 beats promotion");
    critReq = 3'b100;
    cycle("R6 promotion beats crit code 3");
    // R7/R8: medium promotion of source 9
    critReq = '0;
    wr(3'd3, 32'h0, "R7 hi select clear");
    wr(3'd4, 32'h1 << (31 - 9), "R7 mid select write");
    periReq = (22'h1 << 9) | (22'h1 << 2);
    mainReq = 17'h1_0000 | (17'h1 << 12);
    cycle("R7 R8 main code 4, peri reports 9");
    mainReq = 17'h0_0001;
    cycle("R7 main code 0 beats promotion");
    // R6/R7: both selects on one source, high wins
    wr(3'd3, 32'h1 << (31 - 9), "R6 hi and mid on 9");
    mainReq = 17'h0_0020;
    cycle("R6 R7 high overrides medium");
    wr(3'd3, 32'h0, "R7 clear hi");
    wr(3'd4, 32'h0, "R7 clear mid");

    // R9: masking a pending source
    mainReq = '0; critReq = '0; periReq = 22'h1 << 5;
    cycle("R9 pending source 5");
    wr(3'd1, 32'h1 << (31 - 5), "R9 mask write cycle keeps old view");
    cycle("R9 masked source gone");
    wr(3'd1, 32'h0, "R9 unmask");

    // random phase
    for (int i = 0; i < 600; i++) begin
      critReq = 3'($urandom);
      mainReq = 17'($urandom & $urandom);
      periReq = 22'($urandom & $urandom & $urandom);
      if (($urandom % 6) == 0) begin
        regAddr = 3'($urandom % 8);
        regWrEn = 1'b1;
        regWrData = $urandom | $urandom;
        if (($urandom % 2) == 0) regWrData = $urandom & $urandom & $urandom;
      end
      cycle("R2 R8 R9 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule